// File: doc/BRIEF.md
# Forward-Channel GPIO Demultiplexer and Pin Mapper

This block takes the one-bit GPIO field that arrives with each received forward-channel frame and sorts it into up to four remote GPIO holding registers. The remote values share the link in time, so a slot counter decides which register a frame belongs to. The cycle length depends on how many remote GPIOs are linked: one frame for a single GPIO, two frames for two, and five frames for three or four. A cycle-start flag that comes with a frame strobe puts the sequence back to slot 0.

Seven local output pins read from the holding registers through an any-to-any crossbar. Each pin has its own output enable and its own 3-bit source select. Besides a remote GPIO, a pin can carry a locally generated frame-sync pulse or a per-pin control bit set by a register. A disabled pin drives 0 and pulls its tri-state drive enable low. This lets the pin bank hand remote sensor-side signals, or local sync, to a processor or to another receiver.

Top module: `fcg_fwd_gpio_map`

## Requirements
- R1: A frame strobe with the cycle-start flag set is treated as slot 0, whatever the counter held. The next strobe is slot 1, or slot 0 when the cycle length is 1.
- R2: With link count 1, remote GPIO 0 takes the frame bit on every frame strobe.
- R3: With link count 2, strobes alternate between slot 0 (remote GPIO 0) and slot 1 (remote GPIO 1), a cycle of two frames.
- R4: With link count 3 or 4, the cycle is five frames. Slots 0 to 3 load remote GPIO 0 to 3 and slot 4 loads nothing. With link count 3 the slot-3 bit is discarded.
- R5: Link count 0, or any value from 5 to 7, stops recovery. All remote GPIO values keep their last state and the slot counter rests at 0.
- R6: A remote GPIO register changes only on a frame strobe that falls in its own slot. It keeps its value through cycles without a strobe and through other slots.
- R7: A synchronous active-low reset clears all remote GPIO registers and the slot counter to 0.
- R8: A pin whose source select is 0 to 3 outputs remote GPIO 0 to 3 respectively. Any remote GPIO may feed any pin, and several pins may share one source.
- R9: Source select 4 outputs the frame-sync input, 5 outputs that pin's own control bit, and 6 or 7 output 0.
- R10: A pin whose output enable is 0 outputs 0 and drives its drive-enable bit low. A pin whose enable is 1 drives its drive-enable bit high.
- R11: The slot counter goes up by one on each strobe and wraps to 0 at the end of the current cycle. If the link count changes while the counter is past the new cycle's last slot, that strobe loads nothing and the counter restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking a received forward-channel frame |
| frame_bit | input | 1 | GPIO data bit carried by the current frame |
| cycle_start | input | 1 | Marks the strobed frame as slot 0 of the GPIO cycle |
| link_cnt | input | 3 | Number of linked remote GPIOs (1 to 4; other values disable recovery) |
| pin_oe | input | 7 | Per-pin output enable |
| pin_sel | input | 21 | Per-pin 3-bit source select, pin p in bits [3p+2:3p] |
| fsync_in | input | 1 | Locally generated frame-sync signal |
| ctrl_bit | input | 7 | Per-pin register-driven control bit |
| pin_out | output | 7 | Output value of each local pin |
| pin_drv_en | output | 7 | Per-pin tri-state drive enable, high when driving |

## Verification
The hardest state to reach from the ports is a slot counter that sits beyond the end of the current cycle. This happens only when the link count drops, for example from four to two, while the counter is at slot 3 or 4. The stimulus gets there by running a five-frame cycle up to its idle slot, switching the link count between strobes, and then checking that the next strobe loads nothing and the sequence restarts at 0. A separate run with three linked GPIOs checks that the slot-3 bit is discarded. Strobes with gaps and random frame bits between them show that the registers hold their values.

// File: rtl/fcg_pkg.sv
// Package: shared sizes, source-select codes and the cycle-length rule
// for the forward-channel GPIO demultiplexer.
// Assumes at most four remote GPIOs share one long cycle of N_REMOTE+1 frames.
package fcg_pkg;

    localparam int N_REMOTE = 4;
    localparam int N_PINS   = 7;
    localparam int SEL_W    = 3;
    localparam int LCNT_W   = 3;
    localparam int SLOT_W   = $clog2(N_REMOTE + 2);
    localparam int IDX_W    = $clog2(N_REMOTE);

    localparam logic [SEL_W-1:0] SRC_FSYNC = SEL_W'(N_REMOTE);
    localparam logic [SEL_W-1:0] SRC_CTRL  = SEL_W'(N_REMOTE + 1);

    // Frames per GPIO cycle for a given link count; 0 means recovery is off.
    function automatic logic [SLOT_W:0] cycle_len(input logic [LCNT_W-1:0] lcnt);
        if (lcnt == LCNT_W'(1))
            return (SLOT_W+1)'(1);
        else if (lcnt == LCNT_W'(2))
            return (SLOT_W+1)'(2);
        else if ((lcnt >= LCNT_W'(3)) && (int'(lcnt) <= N_REMOTE))
            return (SLOT_W+1)'(N_REMOTE + 1);
        else
            return '0;
    endfunction

endpackage

// File: rtl/fcg_slot_seq.sv
// Module: slot sequencer.
// Tracks which slot of the GPIO cycle each frame strobe belongs to and tells
// the holding bank which remote GPIO, if any, takes the frame bit.
// Assumes frame_stb is a single-cycle pulse and link_cnt is quasi-static.
module fcg_slot_seq
    import fcg_pkg::*;
#(
    parameter int NREM = N_REMOTE,
    parameter int SW   = SLOT_W,
    parameter int IW   = IDX_W,
    parameter int LW   = LCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          cycle_start,
    input  logic [LW-1:0] link_cnt,
    output logic [SW-1:0] slot_q,
    output logic          upd_valid,
    output logic [IW-1:0] upd_idx
);

    logic [SW-1:0] cur_slot;
    logic [SW:0]   len;
    logic [SW:0]   slot_inc;
    logic          enabled;

    // Select the slot of the current frame and the cycle length of this mode.
    always_comb begin
        cur_slot = cycle_start ? '0 : slot_q;
        len      = cycle_len(link_cnt);
        enabled  = (len != '0);
        slot_inc = {1'b0, cur_slot} + (SW+1)'(1);
    end

    // Decide whether this strobe loads a remote register, and which one.
    always_comb begin
        upd_valid = frame_stb && enabled && (int'(cur_slot) < int'(link_cnt));
        upd_idx   = cur_slot[IW-1:0];
    end

    // Advance the slot counter on each strobe, wrapping at the cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (frame_stb) begin
            if (!enabled || (slot_inc >= len))
                slot_q <= '0;
            else
                slot_q <= slot_inc[SW-1:0];
        end
    end

endmodule

// File: rtl/fcg_hold_bank.sv
// Module: remote GPIO holding registers.
// One register per remote GPIO. A register loads the frame bit only when the
// sequencer names it, so it holds its value between its own slots.
// Assumes upd_idx is meaningful only while upd_valid is high.
module fcg_hold_bank
    import fcg_pkg::*;
#(
    parameter int NREM = N_REMOTE,
    parameter int IW   = IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic [IW-1:0]   upd_idx,
    input  logic            frame_bit,
    output logic [NREM-1:0] gpio_q
);

    for (genvar g = 0; g < NREM; g++) begin : g_reg
        // Load remote GPIO g when the current slot belongs to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpio_q[g] <= 1'b0;
            else if (upd_valid && (upd_idx == IW'(g)))
                gpio_q[g] <= frame_bit;
        end
    end

endmodule

// File: rtl/fcg_pin_xbar.sv
// Module: output pin crossbar.
// Every pin picks a remote GPIO, frame-sync or its own control bit through a
// 3-bit select, then gates the result with its output enable.
// Assumes unused select codes above the control code should drive 0.
module fcg_pin_xbar
    import fcg_pkg::*;
#(
    parameter int NREM = N_REMOTE,
    parameter int NP   = N_PINS,
    parameter int SW   = SEL_W
) (
    input  logic [NREM-1:0]  gpio_val,
    input  logic             fsync_in,
    input  logic [NP-1:0]    ctrl_bit,
    input  logic [NP-1:0]    pin_oe,
    input  logic [NP*SW-1:0] pin_sel,
    output logic [NP-1:0]    pin_out,
    output logic [NP-1:0]    pin_drv_en
);

    for (genvar p = 0; p < NP; p++) begin : g_pin
        logic [SW-1:0] sel;
        logic          src;

        assign sel = pin_sel[p*SW +: SW];

        // Pick the source for pin p according to its select code.
        always_comb begin
            if (int'(sel) < NREM)
                src = gpio_val[sel[$clog2(NREM)-1:0]];
            else if (sel == SRC_FSYNC)
                src = fsync_in;
            else if (sel == SRC_CTRL)
                src = ctrl_bit[p];
            else
                src = 1'b0;
        end

        // Gate pin p by its enable and drive its tri-state control.
        always_comb begin
            pin_out[p]    = pin_oe[p] & src;
            pin_drv_en[p] = pin_oe[p];
        end
    end

endmodule

// File: rtl/fcg_fwd_gpio_map.sv
// Module: forward-channel GPIO demultiplexer and pin mapper (top).
// Sorts per-frame GPIO bits into remote holding registers and routes them,
// or local sync and control bits, onto a bank of output pins.
// Assumes a frame strobe lasts one clock and the config inputs change between strobes.
module fcg_fwd_gpio_map
    import fcg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic                    frame_bit,
    input  logic                    cycle_start,
    input  logic [LCNT_W-1:0]       link_cnt,
    input  logic [N_PINS-1:0]       pin_oe,
    input  logic [N_PINS*SEL_W-1:0] pin_sel,
    input  logic                    fsync_in,
    input  logic [N_PINS-1:0]       ctrl_bit,
    output logic [N_PINS-1:0]       pin_out,
    output logic [N_PINS-1:0]       pin_drv_en
);

    logic [SLOT_W-1:0]   slot_q;
    logic                upd_valid;
    logic [IDX_W-1:0]    upd_idx;
    logic [N_REMOTE-1:0] gpio_val;

    fcg_slot_seq #(
        .NREM(N_REMOTE), .SW(SLOT_W), .IW(IDX_W), .LW(LCNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .cycle_start(cycle_start),
        .link_cnt   (link_cnt),
        .slot_q     (slot_q),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx)
    );

    fcg_hold_bank #(
        .NREM(N_REMOTE), .IW(IDX_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_valid(upd_valid),
        .upd_idx  (upd_idx),
        .frame_bit(frame_bit),
        .gpio_q   (gpio_val)
    );

    fcg_pin_xbar #(
        .NREM(N_REMOTE), .NP(N_PINS), .SW(SEL_W)
    ) u_xbar (
        .gpio_val  (gpio_val),
        .fsync_in  (fsync_in),
        .ctrl_bit  (ctrl_bit),
        .pin_oe    (pin_oe),
        .pin_sel   (pin_sel),
        .pin_out   (pin_out),
        .pin_drv_en(pin_drv_en)
    );

endmodule

// File: rtl/fcg_fwd_gpio_map_chk.sv
// Module: assertion checker for fcg_fwd_gpio_map, attached by bind.
// Watches ports together with the slot counter and the remote holding registers.
module fcg_fwd_gpio_map_chk
    import fcg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                frame_stb,
    input logic                frame_bit,
    input logic                cycle_start,
    input logic [LCNT_W-1:0]   link_cnt,
    input logic [N_PINS-1:0]   pin_oe,
    input logic [N_PINS-1:0]   pin_out,
    input logic [SLOT_W-1:0]   slot_q,
    input logic [N_REMOTE-1:0] gpio_val
);

    // R10
    oe_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R6
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(gpio_val));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_cnt == '0 || int'(link_cnt) > N_REMOTE) |=> $stable(gpio_val));

    // R11
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot_q) <= N_REMOTE);

    // R2
    single_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && link_cnt == LCNT_W'(1)) |=> gpio_val[0] == $past(frame_bit));

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cycle_start && link_cnt == LCNT_W'(2)) |=> slot_q == SLOT_W'(1));

    // R4
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !cycle_start && int'(slot_q) == N_REMOTE) |=> $stable(gpio_val));

endmodule

bind fcg_fwd_gpio_map fcg_fwd_gpio_map_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .frame_bit  (frame_bit),
    .cycle_start(cycle_start),
    .link_cnt   (link_cnt),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .slot_q     (slot_q),
    .gpio_val   (gpio_val)
);

// File: tb/fcg_fwd_gpio_map_test.sv
// Bench: behavioural reference model compared with the pins on every clock.
module fcg_fwd_gpio_map_test;

    localparam int PER = 10;
    localparam int NP  = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_stb, frame_bit, cycle_start, fsync_in;
    logic [2:0]  link_cnt;
    logic [6:0]  pin_oe, ctrl_bit, pin_out, pin_drv_en;
    logic [20:0] pin_sel;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    int m_cnt = 0;
    bit m_hold [4] = '{0, 0, 0, 0};
    string tag = "R7";

    always #(PER/2) clk = ~clk;

    fcg_fwd_gpio_map uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_bit(frame_bit),
        .cycle_start(cycle_start), .link_cnt(link_cnt), .pin_oe(pin_oe),
        .pin_sel(pin_sel), .fsync_in(fsync_in), .ctrl_bit(ctrl_bit),
        .pin_out(pin_out), .pin_drv_en(pin_drv_en)
    );

    task automatic check(input logic act, input logic exp, input string req, input int pin);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s pin %0d at %0t: actual %b expected %b", req, pin, $time, act, exp);
        end
    endtask

    function automatic int model_len(input int lc);
        if (lc == 1) return 1;
        if (lc == 2) return 2;
        if (lc == 3 || lc == 4) return 5;
        return 0;
    endfunction

    // Apply one clock edge to the model, then compare all pins.
    task automatic step();
        int len, slot;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0;
            foreach (m_hold[i]) m_hold[i] = 0;
        end else if (frame_stb) begin
            len  = model_len(int'(link_cnt));
            slot = cycle_start ? 0 : m_cnt;
            if (len == 0) m_cnt = 0;
            else begin
                if (slot < int'(link_cnt)) m_hold[slot] = frame_bit;
                m_cnt = (slot + 1 >= len) ? 0 : slot + 1;
            end
        end
        #(PER/4);
        for (int p = 0; p < NP; p++) begin
            int  s;
            bit  e;
            string r;
            s = int'(pin_sel[p*3 +: 3]);
            if (s < 4) begin e = m_hold[s]; r = tag; end
            else if (s == 4) begin e = fsync_in; r = "R9"; end
            else if (s == 5) begin e = ctrl_bit[p]; r = "R9"; end
            else begin e = 0; r = "R9"; end
            if (!pin_oe[p]) begin e = 0; r = "R10"; end
            check(pin_out[p], e, r, p);
            check(pin_drv_en[p], pin_oe[p], "R10", p);
        end
    endtask

    task automatic frame(input bit cs);
        frame_stb   = 1'b1;
        cycle_start = cs;
        frame_bit   = 1'($urandom_range(1));
        fsync_in    = 1'($urandom_range(1));
        step();
        frame_stb   = 1'b0;
        cycle_start = 1'b0;
    endtask

    task automatic idle();
        frame_stb = 1'b0;
        frame_bit = 1'($urandom_range(1));
        cycle_start = 1'($urandom_range(1));
        step();
        cycle_start = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PER * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; frame_stb = 0; frame_bit = 0; cycle_start = 0; fsync_in = 0;
        link_cnt = 3'd4; pin_oe = 7'h7F; ctrl_bit = 7'b1010101;
        // pins 0-3 remote 0-3, pin 4 frame-sync, pin 5 control, pin 6 code 6
        pin_sel = {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
        // R7: strobes during reset must not load anything
        tag = "R7";
        for (int i = 0; i < 4; i++) frame(1'b0);
        rst_n = 1'b1;
        idle();

        // R2: one linked GPIO, every frame refreshes remote 0
        tag = "R2"; link_cnt = 3'd1;
        for (int i = 0; i < 20; i++) frame(i == 0);

        // R3: two linked GPIOs alternate
        tag = "R3"; link_cnt = 3'd2;
        for (int i = 0; i < 20; i++) frame(i == 0);

        // R4: four linked, then three linked (slot 3 discarded)
        tag = "R4"; link_cnt = 3'd4;
        for (int i = 0; i < 30; i++) frame(i % 5 == 0);
        link_cnt = 3'd3;
        for (int i = 0; i < 30; i++) frame(i % 5 == 0);

        // R1: cycle-start at irregular points
        tag = "R1"; link_cnt = 3'd4;
        for (int i = 0; i < 30; i++) frame(i % 3 == 0);
        link_cnt = 3'd2;
        for (int i = 0; i < 12; i++) frame(i % 3 == 1);

        // R6: strobes with gaps, bits toggling between them
        tag = "R6"; link_cnt = 3'd4;
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(2) == 0) frame(1'b0);
            else idle();
        end

        // R5: recovery disabled with 0 and 6
        tag = "R5"; link_cnt = 3'd0;
        for (int i = 0; i < 15; i++) frame(i == 3);
        link_cnt = 3'd6;
        for (int i = 0; i < 15; i++) frame(1'b0);

        // R11: drop from five-frame cycle to two while counter is at slot 3 or 4
        tag = "R11";
        for (int k = 3; k <= 4; k++) begin
            link_cnt = 3'd4;
            frame(1'b1);
            for (int i = 0; i < k - 1; i++) frame(1'b0);
            link_cnt = 3'd2;
            for (int i = 0; i < 6; i++) frame(1'b0);
        end

        // R8: random routing and enables over all sources
        tag = "R8"; link_cnt = 3'd4;
        for (int i = 0; i < 200; i++) begin
            pin_sel  = 21'($urandom);
            pin_oe   = 7'($urandom);
            ctrl_bit = 7'($urandom);
            if (i % 7 == 0) idle(); else frame(i % 5 == 0);
        end

        // R9: local sources only, R10 with enables off
        tag = "R9";
        pin_oe = 7'h7F;
        pin_sel = {3'd7, 3'd6, 3'd5, 3'd4, 3'd5, 3'd4, 3'd5};
        for (int i = 0; i < 20; i++) begin
            ctrl_bit = 7'($urandom);
            frame(1'b0);
        end
        tag = "R10"; pin_oe = 7'h00;
        for (int i = 0; i < 10; i++) frame(1'b0);

        summary();
    end

endmodule